// File: doc/BRIEF.md
# Cycle-Steal Frame Memory Arbiter

This block shares one single-port, word-wide frame memory between a display refresh reader and a host processor port. A fixed slot timer marks alternate clock cycles as display slots. In a display slot the display reader may fetch one word. The cycles in between are free slots, and host reads and writes are carried out only there. The memory array sits outside the block. The arbiter drives its request, write-enable, byte-enable, word-address and write-data pins, and takes back read data one clock after a read.

A host access that arrives while stealing is enabled raises `host_wait` until the access has been carried out in a free slot. The display therefore never loses a fetch. When stealing is disabled, the host is served in the cycle its request is first seen and `host_wait` stays low. A display fetch that falls in that same cycle is dropped.

The host bus is either 8 or 16 bits wide. On a 16-bit bus the written bytes are chosen in one of two ways: a high-byte enable together with byte address bit 0, or separate low and high write strobes. A lane swap exchanges the two bytes between the host bus and the memory word.

Top module: `fm_steal_arbiter`

## Requirements
- R1: In the first cycle after synchronous active-low reset is released, `disp_slot` is 1, and `host_wait`, `disp_valid`, `mem_en` and `host_rdata` are all 0 (with no display or host request present).
- R2: `disp_slot` is 1 in the first cycle after reset and then changes value on every clock.
- R3: In a display slot where `disp_req` is 1 and no host access is granted, the memory is read at `disp_addr`. In the next cycle `disp_valid` is 1 and `disp_data` carries the word stored at that address. In every other case `disp_valid` is 0 in the next cycle.
- R4: With `steal_en` at 1, a host access is carried out only in a cycle where `disp_slot` is 0. Every memory access in a display slot is the display fetch.
- R5: With `steal_en` at 1, `host_wait` is 1 while a request is present and not yet finished. For a write it falls in the cycle after the write cycle. For a read it falls in the cycle two clocks after the read cycle, which is also the cycle in which `host_rdata` holds the read value.
- R6: With `steal_en` at 0, a host request is carried out in the cycle it is first seen, in either slot kind. `host_wait` stays 0, and a display fetch requested in that cycle is not performed.
- R7: Each host request causes exactly one memory access. No further access is made for it until `host_cs` or all of its strobes have been released for at least one cycle.
- R8: With `bus16` at 0, a write uses `host_wdata[7:0]` and enables only byte lane `host_addr[0]` (lane 0 = bits 7:0, lane 1 = bits 15:8). A read returns that byte in `host_rdata[7:0]` with bits 15:8 at 0. `host_wr_hi` and `swap` have no effect.
- R9: With `bus16` at 1 and `strobe_mode` at 0, the write strobe is `host_wr_lo`. Lane 0 is enabled when `host_addr[0]` is 0 and lane 1 when `host_hi_en` is 1. Host bits 15:8 go to lane 1 and bits 7:0 go to lane 0. A read returns the full word.
- R10: With `bus16` at 1 and `strobe_mode` at 1, `host_wr_lo` enables lane 0 and `host_wr_hi` enables lane 1, and `host_addr[0]` has no effect.
- R11: With `bus16` at 1 and `swap` at 1, host byte lanes 0 and 1 are exchanged for the write data and the byte enables on the way to memory, and for the read data on the way back.
- R12: A host access uses word address `host_addr[14:1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| steal_en | input | 1 | 1: host fitted into free slots with wait; 0: host served at once |
| bus16 | input | 1 | 1: 16-bit host bus; 0: 8-bit host bus |
| strobe_mode | input | 1 | 16-bit lane select: 0 high-enable plus address bit 0, 1 separate strobes |
| swap | input | 1 | Exchange the two byte lanes on a 16-bit bus |
| host_cs | input | 1 | Host frame memory select |
| host_rd | input | 1 | Host read strobe |
| host_wr_lo | input | 1 | Host write strobe (low lane in strobe mode) |
| host_wr_hi | input | 1 | Host high lane write strobe (strobe mode only) |
| host_hi_en | input | 1 | Host high byte enable (high-enable mode) |
| host_addr | input | 15 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, registered |
| host_wait | output | 1 | Host access pending |
| disp_slot | output | 1 | Current cycle is a display slot |
| disp_req | input | 1 | Display fetch request for this slot |
| disp_addr | input | 14 | Display word address |
| disp_valid | output | 1 | `disp_data` carries a fetched word |
| disp_data | output | 16 | Fetched display word |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write this cycle |
| mem_be | output | 2 | Memory byte enables |
| mem_addr | output | 14 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one clock after the read |

## Verification
The bench goes after requests that arrive in a display slot, in a free slot and right after a previous completion. A design that granted from the wrong slot kind would show a host write in a display slot. A design with a wrong state sequence would drop `host_wait` a cycle early or late, or write a held request twice. Each lane convention is exercised with every enable combination, including address bit 0 set in strobe mode and swapped reads on both bus widths. A lane-mapping slip shows up as a wrong byte enable or a wrong byte read back. With stealing off and the display requesting in every cycle, a design that still performed the colliding fetch, or that raised wait, is caught by the fetch-valid and wait comparisons.

// File: rtl/fm_steal_pkg.sv
// Shared types for the cycle-steal frame memory arbiter.
package fm_steal_pkg;
    // Host access sequencer states.
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,   // waiting for a request or a grant
        HS_RDATA = 2'd1,   // read issued, memory data arriving
        HS_DONE  = 2'd2    // access finished, waiting for release
    } hstate_e;
endpackage

// File: rtl/fm_slot_timer.sv
// Slot timer: marks one display slot out of every PERIOD cycles.
// Assumes PERIOD >= 2; the first cycle after reset is a display slot.
module fm_slot_timer #(
    parameter int PERIOD = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic disp_slot
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt;

    // Advance the slot counter, wrapping after the last free slot.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign disp_slot = (cnt == '0);
endmodule

// File: rtl/fm_lane_map.sv
// Lane mapper: turns host bus width, lane convention and swap into
// memory byte enables and write data, and extracts host read data
// from a memory word. Purely combinational; assumes two byte lanes.
module fm_lane_map #(
    parameter int BYTE_W = 8
) (
    input  logic                  bus16,
    input  logic                  strobe_mode,
    input  logic                  swap,
    input  logic                  addr_lsb,
    input  logic                  hi_en,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [2*BYTE_W-1:0]   wdata,
    input  logic [2*BYTE_W-1:0]   mem_word,
    output logic [1:0]            be,
    output logic [2*BYTE_W-1:0]   mem_wdata,
    output logic [2*BYTE_W-1:0]   rd_out
);
    localparam int DATA_W = 2 * BYTE_W;

    logic              do_swap;
    logic [1:0]        host_le;
    logic [DATA_W-1:0] host_wd;
    logic [DATA_W-1:0] word_view;

    assign do_swap = bus16 & swap;

    // Host-side lane enables and data before any swap.
    always_comb begin
        if (!bus16) begin
            host_le = addr_lsb ? 2'b10 : 2'b01;
            host_wd = {wdata[BYTE_W-1:0], wdata[BYTE_W-1:0]};
        end else if (strobe_mode) begin
            host_le = {wr_hi, wr_lo};
            host_wd = wdata;
        end else begin
            host_le = {hi_en, ~addr_lsb};
            host_wd = wdata;
        end
    end

    // Apply the optional lane exchange toward memory.
    always_comb begin
        if (do_swap) begin
            be        = {host_le[0], host_le[1]};
            mem_wdata = {host_wd[BYTE_W-1:0], host_wd[DATA_W-1:BYTE_W]};
        end else begin
            be        = host_le;
            mem_wdata = host_wd;
        end
    end

    // Read path: undo the swap, then narrow for an 8-bit bus.
    always_comb begin
        word_view = do_swap ? {mem_word[BYTE_W-1:0], mem_word[DATA_W-1:BYTE_W]}
                            : mem_word;
        if (bus16)
            rd_out = word_view;
        else
            rd_out = {{BYTE_W{1'b0}},
                      addr_lsb ? word_view[DATA_W-1:BYTE_W] : word_view[BYTE_W-1:0]};
    end
endmodule

// File: rtl/fm_host_ctrl.sv
// Host sequencer: grants one memory cycle per host request, in a
// free slot when stealing is on or at once when it is off, and drives
// the wait output. Assumes the host holds its request until wait is
// low and then releases it.
module fm_host_ctrl
    import fm_steal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic is_wr,
    input  logic slot_free,
    input  logic steal_en,
    output logic grant,
    output logic host_wait,
    output logic capture
);
    hstate_e st;

    assign grant     = rst_n & (st == HS_IDLE) & req & (~steal_en | slot_free);
    assign host_wait = rst_n & steal_en & req & (st != HS_DONE);
    assign capture   = (st == HS_RDATA);

    // Step through issue, data return and release for each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= HS_IDLE;
        end else begin
            unique case (st)
                HS_IDLE:  if (grant) st <= is_wr ? HS_DONE : HS_RDATA;
                HS_RDATA: st <= HS_DONE;
                HS_DONE:  if (!req) st <= HS_IDLE;
                default:  st <= HS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fm_steal_arbiter.sv
// Cycle-steal frame memory arbiter top. Shares one external
// single-port synchronous memory (one-clock read latency) between a
// display reader, served in display slots, and a host port, served in
// free slots with wait or immediately when stealing is off.
module fm_steal_arbiter #(
    parameter int ADDR_W      = 15,
    parameter int BYTE_W      = 8,
    parameter int SLOT_PERIOD = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   steal_en,
    input  logic                   bus16,
    input  logic                   strobe_mode,
    input  logic                   swap,
    input  logic                   host_cs,
    input  logic                   host_rd,
    input  logic                   host_wr_lo,
    input  logic                   host_wr_hi,
    input  logic                   host_hi_en,
    input  logic [ADDR_W-1:0]      host_addr,
    input  logic [2*BYTE_W-1:0]    host_wdata,
    output logic [2*BYTE_W-1:0]    host_rdata,
    output logic                   host_wait,
    output logic                   disp_slot,
    input  logic                   disp_req,
    input  logic [ADDR_W-2:0]      disp_addr,
    output logic                   disp_valid,
    output logic [2*BYTE_W-1:0]    disp_data,
    output logic                   mem_en,
    output logic                   mem_we,
    output logic [1:0]             mem_be,
    output logic [ADDR_W-2:0]      mem_addr,
    output logic [2*BYTE_W-1:0]    mem_wdata,
    input  logic [2*BYTE_W-1:0]    mem_rdata
);
    localparam int DATA_W  = 2 * BYTE_W;
    localparam int WADDR_W = ADDR_W - 1;

    logic              is_wr, req, grant, capture, disp_fetch;
    logic [1:0]        lane_be;
    logic [DATA_W-1:0] lane_wd, lane_rd;

    assign is_wr = host_wr_lo | (bus16 & strobe_mode & host_wr_hi);
    assign req   = host_cs & (host_rd | is_wr);

    fm_slot_timer #(.PERIOD(SLOT_PERIOD)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .disp_slot (disp_slot)
    );

    fm_host_ctrl u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .is_wr     (is_wr),
        .slot_free (~disp_slot),
        .steal_en  (steal_en),
        .grant     (grant),
        .host_wait (host_wait),
        .capture   (capture)
    );

    fm_lane_map #(.BYTE_W(BYTE_W)) u_lanes (
        .bus16       (bus16),
        .strobe_mode (strobe_mode),
        .swap        (swap),
        .addr_lsb    (host_addr[0]),
        .hi_en       (host_hi_en),
        .wr_lo       (host_wr_lo),
        .wr_hi       (host_wr_hi),
        .wdata       (host_wdata),
        .mem_word    (mem_rdata),
        .be          (lane_be),
        .mem_wdata   (lane_wd),
        .rd_out      (lane_rd)
    );

    // A display fetch runs in its slot unless the host took the cycle.
    assign disp_fetch = rst_n & disp_slot & disp_req & ~grant;

    // Memory port multiplexer: host grant first, else display fetch.
    always_comb begin
        mem_en    = grant | disp_fetch;
        mem_we    = grant & is_wr;
        mem_addr  = grant ? host_addr[ADDR_W-1:1] : disp_addr;
        mem_be    = mem_we ? lane_be : 2'b00;
        mem_wdata = mem_we ? lane_wd : '0;
    end

    assign disp_data = mem_rdata;

    // Flag that the memory output holds a display word this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) disp_valid <= 1'b0;
        else        disp_valid <= disp_fetch;
    end

    // Capture host read data as it returns from memory.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (capture) host_rdata <= lane_rd;
    end

    logic unused_w;
    assign unused_w = ^{WADDR_W[0]};
endmodule

// File: rtl/fm_steal_checker.sv
// Property checker for the frame memory arbiter, bound to the top.
module fm_steal_checker #(
    parameter int ADDR_W = 15,
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                steal_en,
    input logic [ADDR_W-1:0]   host_addr,
    input logic                host_wait,
    input logic                disp_slot,
    input logic                disp_req,
    input logic [ADDR_W-2:0]   disp_addr,
    input logic                disp_valid,
    input logic                mem_en,
    input logic                mem_we,
    input logic [ADDR_W-2:0]   mem_addr
);
    logic past_ok;

    // Mark cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2: the slot marker alternates every clock.
    assert_slot_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (disp_slot != $past(disp_slot)));

    // R4: with stealing on, display slots carry only the display fetch.
    assert_display_slot_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (steal_en && disp_slot && mem_en) |-> (!mem_we && disp_req && mem_addr == disp_addr));

    // R3: fetched data is flagged only after a display read in a display slot.
    assert_fetch_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && disp_valid) |-> $past(disp_slot && disp_req && mem_en && !mem_we
                                           && mem_addr == disp_addr));

    // R6: no wait is ever raised while stealing is off.
    assert_no_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !steal_en |-> !host_wait);

    // R12: host writes target the host word address.
    assert_write_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == host_addr[ADDR_W-1:1]));
endmodule

bind fm_steal_arbiter fm_steal_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .steal_en   (steal_en),
    .host_addr  (host_addr),
    .host_wait  (host_wait),
    .disp_slot  (disp_slot),
    .disp_req   (disp_req),
    .disp_addr  (disp_addr),
    .disp_valid (disp_valid),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr)
);

// File: tb/fm_steal_arbiter_bench.sv
// Bench: behavioural reference model compared with the design every cycle.
module fm_steal_arbiter_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic steal_en = 1'b1, bus16 = 1'b1, strobe_mode = 1'b0, swap = 1'b0;
    logic host_cs = 1'b0, host_rd = 1'b0, host_wr_lo = 1'b0, host_wr_hi = 1'b0, host_hi_en = 1'b0;
    logic [14:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic host_wait, disp_slot, disp_valid, mem_en, mem_we;
    logic disp_req = 1'b0;
    logic [13:0] disp_addr = '0;
    logic [15:0] disp_data, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [1:0]  mem_be;
    logic [13:0] mem_addr;

    always #10 clk = ~clk;

    fm_steal_arbiter u_fm_steal_arbiter (.*);

    // Bench-side memory array driven by the design's memory port.
    logic [15:0] sram [int];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                logic [15:0] w;
                w = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 16'h0;
                if (mem_be[0]) w[7:0]  = mem_wdata[7:0];
                if (mem_be[1]) w[15:8] = mem_wdata[15:8];
                sram[int'(mem_addr)] = w;
            end else begin
                mem_rdata <= sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 16'h0;
            end
        end
    end

    // Reference model state.
    logic [15:0] ref_mem [int];
    int  n_cmp = 0, n_bad = 0, n_cyc = 0;
    int  m_phase = 0, m_state = 0;
    bit  m_dvalid = 0, m_lastrd = 0, force_disp = 0;
    logic [15:0] m_dexp = '0, m_rexp = '0;
    int unsigned lfsr = 32'h1d2c3b4a;

    function automatic logic [15:0] ref_word(int a);
        return ref_mem.exists(a) ? ref_mem[a] : 16'h0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string lane_tag();
        if (bus16 && swap) return "R11";
        if (!bus16)        return "R8";
        return strobe_mode ? "R10" : "R9";
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // One cycle: drive display inputs, compare against the model, step it.
    task automatic cycle();
        bit wr, req, grant, fetch;
        logic [1:0] le;
        logic [15:0] d, w, mask;
        int ha;
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hA3000000 : 32'h0);
        disp_req  = force_disp ? 1'b1 : lfsr[0];
        disp_addr = 14'(lfsr[4:1] + 14'h100);
        #1;
        wr    = host_wr_lo || (bus16 && strobe_mode && host_wr_hi);
        req   = host_cs && (host_rd || wr);
        grant = (m_state == 0) && req && (!steal_en || m_phase == 1);
        fetch = (m_phase == 0) && disp_req && !grant;
        ha    = int'(host_addr >> 1);
        if (!bus16) begin
            le = host_addr[0] ? 2'b10 : 2'b01;
            d  = {host_wdata[7:0], host_wdata[7:0]};
        end else begin
            d  = host_wdata;
            le = strobe_mode ? {host_wr_hi, host_wr_lo} : {host_hi_en, !host_addr[0]};
            if (swap) begin le = {le[0], le[1]}; d = {d[7:0], d[15:8]}; end
        end
        check("R2 disp_slot", 32'(disp_slot), 32'(m_phase == 0));
        check(steal_en ? "R5 host_wait" : "R6 host_wait", 32'(host_wait),
              32'(steal_en && req && m_state != 2));
        check(m_state == 2 ? "R7 mem_en" : (steal_en ? "R4 mem_en" : "R6 mem_en"),
              32'(mem_en), 32'(grant || fetch));
        check("R4 mem_we", 32'(mem_we), 32'(grant && wr));
        if (grant) check("R12 mem_addr", 32'(mem_addr), 32'(ha));
        else if (fetch) check("R3 mem_addr", 32'(mem_addr), 32'(disp_addr));
        if (grant && wr) begin
            mask = {{8{le[1]}}, {8{le[0]}}};
            check({lane_tag(), " mem_be"}, 32'(mem_be), 32'(le));
            check({lane_tag(), " mem_wdata"}, 32'(mem_wdata & mask), 32'(d & mask));
        end
        check(steal_en ? "R3 disp_valid" : "R6 disp_valid", 32'(disp_valid), 32'(m_dvalid));
        if (m_dvalid) check("R3 disp_data", 32'(disp_data), 32'(m_dexp));
        if (m_state == 2 && m_lastrd) check({lane_tag(), " host_rdata"}, 32'(host_rdata), 32'(m_rexp));
        // Model step.
        m_dvalid = fetch;
        if (fetch) m_dexp = ref_word(int'(disp_addr));
        if (grant && wr) begin
            w = ref_word(ha);
            if (le[0]) w[7:0]  = d[7:0];
            if (le[1]) w[15:8] = d[15:8];
            ref_mem[ha] = w;
            m_state = 2; m_lastrd = 0;
        end else if (grant) begin
            w = ref_word(ha);
            if (bus16 && swap) w = {w[7:0], w[15:8]};
            m_rexp = bus16 ? w : {8'h0, host_addr[0] ? w[15:8] : w[7:0]};
            m_state = 1; m_lastrd = 1;
        end else if (m_state == 1) m_state = 2;
        else if (m_state == 2 && !req) m_state = 0;
        m_phase = (m_phase + 1) % 2;
        n_cyc++;
        if (n_cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", n_cyc);
            finish_run();
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    // One host transaction, held until done, then released.
    task automatic xact(bit wr, int addr, logic [15:0] d, bit hi, bit wlo, bit whi);
        int guard;
        host_addr = 15'(addr); host_wdata = d; host_hi_en = hi;
        host_cs = 1'b1; host_rd = !wr;
        host_wr_lo = wr && wlo; host_wr_hi = wr && whi;
        guard = 0;
        do begin cycle(); guard++; end while (m_state != 2 && guard < 20);
        cycle();
        host_cs = 1'b0; host_rd = 1'b0; host_wr_lo = 1'b0; host_wr_hi = 1'b0;
        cycle();
    endtask

    initial begin
        #(20 * 190000);
        n_bad++;
        $display("FAIL watchdog timer expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: state right after reset release.
        check("R1 disp_slot", 32'(disp_slot), 32'd1);
        check("R1 host_wait", 32'(host_wait), 32'd0);
        check("R1 disp_valid", 32'(disp_valid), 32'd0);
        check("R1 mem_en", 32'(mem_en), 32'd0);
        check("R1 host_rdata", 32'(host_rdata), 32'd0);
        idle(3);
        // R9: high-enable convention with stealing.
        xact(1, 15'h0200, 16'hA1B2, 1, 1, 0);
        xact(0, 15'h0200, 16'h0, 1, 0, 0);
        idle(1);
        xact(1, 15'h0201, 16'h5C00, 1, 1, 0);
        xact(1, 15'h0200, 16'h00E7, 0, 1, 0);
        xact(1, 15'h0201, 16'hFFFF, 0, 1, 0);
        xact(0, 15'h0200, 16'h0, 1, 0, 0);
        // R10: separate strobes, address bit 0 ignored.
        strobe_mode = 1'b1;
        xact(1, 15'h0301, 16'h1234, 0, 0, 1);
        xact(1, 15'h0300, 16'hABCD, 0, 1, 0);
        idle(1);
        xact(0, 15'h0301, 16'h0, 0, 0, 0);
        xact(1, 15'h0302, 16'h7788, 0, 1, 1);
        xact(0, 15'h0302, 16'h0, 0, 0, 0);
        // R8: 8-bit bus, with swap set having no effect.
        bus16 = 1'b0; strobe_mode = 1'b0;
        xact(1, 15'h0400, 16'hEE11, 0, 1, 0);
        xact(1, 15'h0401, 16'hEE22, 0, 1, 1);
        xact(0, 15'h0401, 16'h0, 0, 0, 0);
        xact(0, 15'h0400, 16'h0, 0, 0, 0);
        swap = 1'b1;
        xact(0, 15'h0201, 16'h0, 0, 0, 0);
        // R11: swapped 16-bit lanes.
        bus16 = 1'b1;
        xact(1, 15'h0500, 16'hC3D4, 1, 1, 0);
        xact(1, 15'h0502, 16'h00AA, 0, 1, 0);
        swap = 1'b0;
        xact(0, 15'h0500, 16'h0, 0, 0, 0);
        xact(0, 15'h0502, 16'h0, 0, 0, 0);
        swap = 1'b1;
        xact(0, 15'h0500, 16'h0, 0, 0, 0);
        swap = 1'b0;
        // R6: stealing off, display requesting every cycle.
        steal_en = 1'b0; force_disp = 1;
        for (int g = 0; g < 4; g++) begin
            idle(g);
            xact(1, 15'h0600 + 2 * g, 16'h1111 * 16'(g + 1), 1, 1, 0);
            xact(0, 15'h0600 + 2 * g, 16'h0, 1, 0, 0);
        end
        force_disp = 0;
        // Mixed traffic with varied gaps in both arbitration modes.
        for (int k = 0; k < 40; k++) begin
            steal_en = (k % 5) != 0;
            strobe_mode = k[1];
            swap = k[2];
            bus16 = (k % 7) != 3;
            idle(k % 3);
            xact(1, 15'h0100 + k, 16'h3C5A ^ 16'(k * 97), k[0], 1, k[3]);
            xact(0, 15'h0100 + k, 16'h0, 1, 0, 0);
        end
        idle(4);
        finish_run();
    end
endmodule